// File: doc/BRIEF.md
# Traceback Path Walker

This block performs the backtracking half of a local sequence alignment. A scoring pass, which lies outside the block, fills one 2-bit direction memory per query column. It writes through the block's forward write port, one row address at a time. When that pass is done, a start pulse hands the walker the row and column of the highest score. From there the walker reads one direction code per step and moves to the next cell that the code names. Each visited cell is emitted as a (row, column, direction) entry with a valid strobe.

The walker owns the address bus of every column memory. While it is idle, each memory is addressed by the forward write address and accepts writes from its write enable. While a walk is running, the walker's own read address drives every memory and all forward writes are blocked. No score is recomputed. The stored code alone picks the next position, so a walk takes time linear in the path length.

Direction codes are 1 (vertical: row minus one, same column), 2 (diagonal: row and column minus one), 3 (horizontal: same row, column minus one) and 0 (no predecessor). Rows run from 1 to NROWS and columns from 1 to NCOLS. Row 0 and column 0 are the zero border of the score matrix. Write-enable bit k selects column k+1.

Top module: `trace_walker`

## Requirements
- R1: After a synchronous reset the block is idle: busy, step_valid, col_handoff and done are all 0.
- R2: A start pulse sampled while idle, with a nonzero row and column, sets busy on the next cycle. The first entry carries exactly that row and column and appears on the third rising edge, counting the edge that sampled start as the first.
- R3: While idle, a rising edge with fwd_we bit k set stores fwd_code at row fwd_addr of column k+1. While busy, every forward write is ignored and the stored codes stay unchanged.
- R4: An entry with code 3 is followed by an entry in the same row and the previous column.
- R5: An entry with code 1 is followed by an entry in the previous row and the same column.
- R6: An entry with code 2 is followed by an entry in the previous row and the previous column.
- R7: Each step takes two cycles. Successive entries of one walk are exactly two cycles apart, and step_valid is never high on two consecutive cycles.
- R8: col_handoff is high with an entry exactly when that entry's code is 2 or 3 and the walk continues into the previous column.
- R9: A walk ends, with a one-cycle done pulse, on either of two events. If the next row or column would be 0, done is raised together with the final entry. If a code of 0 is read, no entry is produced for that cell and done is raised two cycles after the previous entry (three edges after start if there was none).
- R10: A start pulse with row 0 or column 0 produces no entry, raises done on the next cycle and leaves busy low.
- R11: A start pulse that arrives while a walk is busy is ignored. The running walk's entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fwd_we | input | NCOLS | Per-column forward write enable (bit k is column k+1) |
| fwd_addr | input | ROW_W | Forward write row address |
| fwd_code | input | 2 | Direction code to store |
| start | input | 1 | Traceback start pulse |
| start_row | input | ROW_W | Row of the maximum score |
| start_col | input | COL_W | Column of the maximum score |
| busy | output | 1 | Walk in progress; memories addressed by the walker |
| step_valid | output | 1 | Path entry strobe |
| step_row | output | ROW_W | Row of the current entry |
| step_col | output | COL_W | Column of the current entry |
| step_dir | output | 2 | Direction code read for the current entry |
| col_handoff | output | 1 | Walk moves on to the previous column |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
A corrupted position register shows up at the very next entry, two cycles later. The row and column stop following the previous code's move, or an entry appears with a zero coordinate. A wrong state or an address mux stuck on the wrong source shows up as a bad entry spacing, a missing or early done, or codes that do not match the contents the bench loaded. A leaking forward write during a walk does not show at once. It appears on a later walk that crosses the overwritten cells, which is why that walk is repeated straight after the disturbed one.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DIAG = 2'd2,
    DIR_LEFT = 2'd3
  } dir_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EVAL = 2'd2
  } walk_st_e;
endpackage

// File: rtl/tw_dir_mem.sv
module tw_dir_mem #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              sel_trace,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        wr_code,
  output logic [1:0]        rd_code
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0]        mem [DEPTH];
  logic [ADDR_W-1:0] addr_mux;
  logic              we_eff;

  // single address bus: forward writer when idle, walker while tracing
  always_comb begin
    addr_mux = sel_trace ? rd_addr : wr_addr;
    we_eff   = wr_en & ~sel_trace;
  end

  always_ff @(posedge clk) begin
    if (we_eff) begin
      mem[addr_mux] <= wr_code;
    end
    rd_code <= mem[addr_mux];
  end
endmodule

// File: rtl/tw_step_calc.sv
module tw_step_calc
  import tw_pkg::*;
#(
  parameter int ROW_W = 5,
  parameter int COL_W = 4
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  dir_e             code,
  output logic [ROW_W-1:0] nxt_row,
  output logic [COL_W-1:0] nxt_col,
  output logic             moves_col,
  output logic             reaches_edge
);
  logic [ROW_W-1:0] row_dec;
  logic [COL_W-1:0] col_dec;

  // clamped decrements: never wrap below zero
  always_comb begin
    row_dec = (row == '0) ? '0 : row - 1'b1;
    col_dec = (col == '0) ? '0 : col - 1'b1;
    nxt_row = row;
    nxt_col = col;
    unique case (code)
      DIR_UP:   nxt_row = row_dec;
      DIR_DIAG: begin
        nxt_row = row_dec;
        nxt_col = col_dec;
      end
      DIR_LEFT: nxt_col = col_dec;
      default:  ;
    endcase
    moves_col    = (code == DIR_DIAG) || (code == DIR_LEFT);
    reaches_edge = (nxt_row == '0) || (nxt_col == '0);
  end
endmodule

// File: rtl/tw_walk_ctrl.sv
module tw_walk_ctrl
  import tw_pkg::*;
#(
  parameter int ROW_W = 5,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ROW_W-1:0] start_row,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       code_in,
  output logic [ROW_W-1:0] cur_row,
  output logic [COL_W-1:0] cur_col,
  output logic             busy,
  output logic             step_valid,
  output logic [ROW_W-1:0] step_row,
  output logic [COL_W-1:0] step_col,
  output logic [1:0]       step_dir,
  output logic             col_handoff,
  output logic             done
);
  walk_st_e         st;
  dir_e             code;
  logic [ROW_W-1:0] nxt_row;
  logic [COL_W-1:0] nxt_col;
  logic             moves_col;
  logic             reaches_edge;

  assign code = dir_e'(code_in);
  assign busy = (st != ST_IDLE);

  tw_step_calc #(.ROW_W(ROW_W), .COL_W(COL_W)) calc_i (
    .row          (cur_row),
    .col          (cur_col),
    .code         (code),
    .nxt_row      (nxt_row),
    .nxt_col      (nxt_col),
    .moves_col    (moves_col),
    .reaches_edge (reaches_edge)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cur_row     <= '0;
      cur_col     <= '0;
      step_valid  <= 1'b0;
      step_row    <= '0;
      step_col    <= '0;
      step_dir    <= '0;
      col_handoff <= 1'b0;
      done        <= 1'b0;
    end else begin
      step_valid  <= 1'b0;
      col_handoff <= 1'b0;
      done        <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            if (start_row == '0 || start_col == '0) begin
              done <= 1'b1;
            end else begin
              cur_row <= start_row;
              cur_col <= start_col;
              st      <= ST_READ;
            end
          end
        end
        // address presented this cycle; memory output registers at the edge
        ST_READ: st <= ST_EVAL;
        ST_EVAL: begin
          if (code == DIR_NONE) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            step_valid <= 1'b1;
            step_row   <= cur_row;
            step_col   <= cur_col;
            step_dir   <= code_in;
            cur_row    <= nxt_row;
            cur_col    <= nxt_col;
            if (reaches_edge) begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              col_handoff <= moves_col;
              st          <= ST_READ;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trace_walker.sv
module trace_walker #(
  parameter int NROWS = 16,
  parameter int NCOLS = 8,
  localparam int ROW_W = $clog2(NROWS + 1),
  localparam int COL_W = $clog2(NCOLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCOLS-1:0] fwd_we,
  input  logic [ROW_W-1:0] fwd_addr,
  input  logic [1:0]       fwd_code,
  input  logic             start,
  input  logic [ROW_W-1:0] start_row,
  input  logic [COL_W-1:0] start_col,
  output logic             busy,
  output logic             step_valid,
  output logic [ROW_W-1:0] step_row,
  output logic [COL_W-1:0] step_col,
  output logic [1:0]       step_dir,
  output logic             col_handoff,
  output logic             done
);
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic [1:0]       rd_code [NCOLS];
  logic [1:0]       code_sel;

  for (genvar g = 0; g < NCOLS; g++) begin : g_col
    tw_dir_mem #(.ADDR_W(ROW_W)) mem_i (
      .clk       (clk),
      .sel_trace (busy),
      .wr_en     (fwd_we[g]),
      .wr_addr   (fwd_addr),
      .rd_addr   (cur_row),
      .wr_code   (fwd_code),
      .rd_code   (rd_code[g])
    );
  end

  // pick the code of the column the walk currently stands in
  always_comb begin
    code_sel = 2'd0;
    for (int i = 0; i < NCOLS; i++) begin
      if (cur_col == COL_W'(i + 1)) code_sel = rd_code[i];
    end
  end

  tw_walk_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_row   (start_row),
    .start_col   (start_col),
    .code_in     (code_sel),
    .cur_row     (cur_row),
    .cur_col     (cur_col),
    .busy        (busy),
    .step_valid  (step_valid),
    .step_row    (step_row),
    .step_col    (step_col),
    .step_dir    (step_dir),
    .col_handoff (col_handoff),
    .done        (done)
  );
endmodule

// File: rtl/trace_walker_chk.sv
module trace_walker_chk #(
  parameter int NROWS = 16,
  parameter int NCOLS = 8,
  localparam int ROW_W = $clog2(NROWS + 1),
  localparam int COL_W = $clog2(NCOLS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [ROW_W-1:0] start_row,
  input logic [COL_W-1:0] start_col,
  input logic             busy,
  input logic             step_valid,
  input logic [ROW_W-1:0] step_row,
  input logic [COL_W-1:0] step_col,
  input logic [1:0]       step_dir,
  input logic             col_handoff,
  input logic             done
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && start_row != '0 && start_col != '0) |=> busy);

  // R10
  zero_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && (start_row == '0 || start_col == '0)) |=> (done && !busy && !step_valid));

  // R7
  step_gap_chk: assert property (@(posedge clk) disable iff (rst)
    step_valid |=> !step_valid);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  entry_inside_chk: assert property (@(posedge clk) disable iff (rst)
    step_valid |-> (step_row != '0 && step_col != '0));

  // R8
  handoff_chk: assert property (@(posedge clk) disable iff (rst)
    col_handoff |-> (step_valid && !done && (step_dir == 2'd2 || step_dir == 2'd3)));

  // R5
  vert_move_chk: assert property (@(posedge clk) disable iff (rst)
    (step_valid && $past(step_valid, 2) && $past(step_dir, 2) == 2'd1) |->
    (step_row == $past(step_row, 2) - 1'b1 && step_col == $past(step_col, 2)));

  // R6
  diag_move_chk: assert property (@(posedge clk) disable iff (rst)
    (step_valid && $past(step_valid, 2) && $past(step_dir, 2) == 2'd2) |->
    (step_row == $past(step_row, 2) - 1'b1 && step_col == $past(step_col, 2) - 1'b1));

  // R4
  horiz_move_chk: assert property (@(posedge clk) disable iff (rst)
    (step_valid && $past(step_valid, 2) && $past(step_dir, 2) == 2'd3) |->
    (step_row == $past(step_row, 2) && step_col == $past(step_col, 2) - 1'b1));
endmodule

bind trace_walker trace_walker_chk #(.NROWS(NROWS), .NCOLS(NCOLS)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .start_row   (start_row),
  .start_col   (start_col),
  .busy        (busy),
  .step_valid  (step_valid),
  .step_row    (step_row),
  .step_col    (step_col),
  .step_dir    (step_dir),
  .col_handoff (col_handoff),
  .done        (done)
);

// File: tb/trace_walker_tb_top.sv
module trace_walker_tb_top;
  localparam int NROWS   = 16;
  localparam int NCOLS   = 8;
  localparam int ROW_W   = $clog2(NROWS + 1);
  localparam int COL_W   = $clog2(NCOLS + 1);
  localparam int CLK_PER = 10;
  localparam int MAXE    = 64;
  localparam int NV      = 8;

  // walk table: start row, start col, disturb with forward writes, restart while busy
  localparam int WALK_TAB [NV][4] = '{
    '{16, 8, 0, 0},
    '{ 8, 5, 0, 0},
    '{ 7, 4, 0, 0},
    '{ 1, 2, 0, 0},
    '{ 1, 1, 0, 0},
    '{12, 6, 1, 0},
    '{12, 6, 0, 0},
    '{15, 7, 0, 1}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NCOLS-1:0] fwd_we = '0;
  logic [ROW_W-1:0] fwd_addr = '0;
  logic [1:0]       fwd_code = '0;
  logic             start = 1'b0;
  logic [ROW_W-1:0] start_row = '0;
  logic [COL_W-1:0] start_col = '0;
  logic             busy, step_valid, col_handoff, done;
  logic [ROW_W-1:0] step_row;
  logic [COL_W-1:0] step_col;
  logic [1:0]       step_dir;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PER / 2) clk = ~clk;

  trace_walker #(.NROWS(NROWS), .NCOLS(NCOLS)) dut_i (
    .clk(clk), .rst(rst), .fwd_we(fwd_we), .fwd_addr(fwd_addr), .fwd_code(fwd_code),
    .start(start), .start_row(start_row), .start_col(start_col), .busy(busy),
    .step_valid(step_valid), .step_row(step_row), .step_col(step_col),
    .step_dir(step_dir), .col_handoff(col_handoff), .done(done)
  );

  // stored pattern: code 0 at one cell, otherwise 1..3 from row and column
  function automatic int pat(int r, int c);
    if (r == 7 && c == 4) return 0;
    return ((r + c) % 3) + 1;
  endfunction

  task automatic check(bit ok, string req, string what, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic string dir_req(int d);
    if (d == 1) return "R5";
    if (d == 2) return "R6";
    return "R4";
  endfunction

  task automatic run_walk(int sr, int sc, bit disturb, bit restart, string tag);
    int er[MAXE], ec[MAXE], ed[MAXE], eh[MAXE];
    int gr[MAXE], gc[MAXE], gd[MAXE], gh[MAXE], gt[MAXE];
    int n = 0, got_n = 0, r = sr, c = sc, exp_done, done_cyc = -1, cyc = 0;
    bit zero_end = 1'b0;
    // expected path from the walking rules
    if (r != 0 && c != 0) begin
      while (n < MAXE) begin
        int d = pat(r, c);
        int nr, nc;
        bit cont;
        if (d == 0) begin
          zero_end = 1'b1;
          break;
        end
        nr = (d == 3) ? r : r - 1;
        nc = (d == 1) ? c : c - 1;
        cont = (nr > 0) && (nc > 0);
        er[n] = r; ec[n] = c; ed[n] = d; eh[n] = (d != 1 && cont) ? 1 : 0;
        n++;
        r = nr; c = nc;
        if (!cont) break;
      end
    end
    if (sr == 0 || sc == 0) exp_done = 1;
    else if (zero_end) exp_done = 3 + 2 * n;
    else exp_done = 3 + 2 * (n - 1);

    @(negedge clk);
    start = 1'b1;
    start_row = ROW_W'(sr);
    start_col = COL_W'(sc);
    while (cyc < 200) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (restart && cyc == 2) begin
        start = 1'b1;
        start_row = ROW_W'(3);
        start_col = COL_W'(2);
      end
      if (disturb) begin
        fwd_we = '1;
        fwd_addr = ROW_W'(cyc % (NROWS + 1));
        fwd_code = 2'd0;
      end
      if (step_valid && got_n < MAXE) begin
        gr[got_n] = int'(step_row); gc[got_n] = int'(step_col);
        gd[got_n] = int'(step_dir); gh[got_n] = int'(col_handoff); gt[got_n] = cyc;
        got_n++;
      end
      if (done) begin
        done_cyc = cyc;
        break;
      end
    end
    start = 1'b0;
    fwd_we = '0;

    check(got_n == n, (sr == 0 || sc == 0) ? "R10" : "R9", {tag, " entry count"}, got_n, n);
    for (int k = 0; k < n && k < got_n; k++) begin
      string rq = (k == 0) ? "R2" : dir_req(ed[k - 1]);
      check(gr[k] == er[k] && gc[k] == ec[k], rq, {tag, " entry row*100+col"},
            gr[k] * 100 + gc[k], er[k] * 100 + ec[k]);
      check(gd[k] == ed[k], "R3", {tag, " stored code read"}, gd[k], ed[k]);
      check(gh[k] == eh[k], "R8", {tag, " column handoff"}, gh[k], eh[k]);
      check(gt[k] == 3 + 2 * k, (k == 0) ? "R2" : "R7", {tag, " entry cycle"}, gt[k], 3 + 2 * k);
    end
    check(done_cyc == exp_done, (sr == 0 || sc == 0) ? "R10" : "R9", {tag, " done cycle"},
          done_cyc, exp_done);
    @(negedge clk);
    check(!done && !busy && !step_valid, "R9", {tag, " idle after done"},
          int'({done, busy, step_valid}), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!busy && !step_valid && !col_handoff && !done, "R1", "outputs in reset",
          int'({busy, step_valid, col_handoff, done}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !step_valid && !col_handoff && !done, "R1", "outputs after reset",
          int'({busy, step_valid, col_handoff, done}), 0);

    // R3 forward fill of every column while idle
    for (int c = 1; c <= NCOLS; c++) begin
      for (int r = 0; r <= NROWS; r++) begin
        fwd_we = NCOLS'(1) << (c - 1);
        fwd_addr = ROW_W'(r);
        fwd_code = 2'(pat(r, c));
        @(negedge clk);
      end
    end
    fwd_we = '0;

    for (int v = 0; v < NV; v++) begin
      string tag = $sformatf("walk%0d", v);
      if (WALK_TAB[v][2] != 0) tag = {tag, " R3 writes during walk"};
      if (WALK_TAB[v][3] != 0) tag = {tag, " R11 restart while busy"};
      run_walk(WALK_TAB[v][0], WALK_TAB[v][1], WALK_TAB[v][2] != 0, WALK_TAB[v][3] != 0, tag);
    end

    // R10 zero row and zero column starts
    run_walk(0, 5, 1'b0, 1'b0, "zero row R10");
    run_walk(5, 0, 1'b0, 1'b0, "zero col R10");
    // R3 contents still intact after the disturbed walk
    run_walk(16, 8, 1'b0, 1'b0, "final R3 recheck");

    // R1 reset in the middle of a walk returns to idle
    @(negedge clk);
    start = 1'b1; start_row = ROW_W'(16); start_col = COL_W'(8);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!busy && !step_valid && !done, "R1", "reset during walk",
          int'({busy, step_valid, done}), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule